// File: doc/BRIEF.md
# Deferred-Priority Command Coordinator

This block sequences a serial field bus that polls a set of internal units, and it also serves commands from an upper-level bus. Internal polling is the default activity. For each unit in turn, the block sends one outbound transaction and then one inbound transaction in which the unit answers. A programmable idle gap follows each unit. Upper-level commands arrive in an external command FIFO and always outrank polling. They are not allowed to preempt a transaction, though. A waiting command is taken at the next transaction boundary or during the idle gap. Each command taken produces one reply word in an external reply FIFO.

Inbound transactions work differently, because the unit keeps talking whatever the block does. Here the boundary is the next received word. The block cuts the reception off there and serves the command. The unit index and the polling phase stay frozen while commands are served, so polling resumes where it stopped. If a reception was cut, the block first asks that unit to send its answer again and then listens to it again. Commands are drained back to back while the command FIFO holds any. Polling resumes only once the FIFO is empty.

States: `ST_GAP` (idle gap between units), `ST_LAUNCH` (one-cycle framer start), `ST_BUSY` (transaction in flight), `ST_TAKE` (pop one command), `ST_REPLY` (push its reply). The transitions are:
- GAP→TAKE when a command is pending.
- GAP→LAUNCH when the gap expires.
- LAUNCH→BUSY always.
- BUSY→TAKE after an outbound done with a command pending, or on a cut.
- BUSY→LAUNCH after an outbound done with no command pending.
- BUSY→GAP after an inbound done.
- TAKE→REPLY always.
- REPLY→TAKE while the FIFO is non-empty.
- REPLY→LAUNCH once it is empty.

Top module: `cmd_coord`

## Requirements
- R1: While reset is held and right after it, `fb_start`, `cq_pop`, `rq_push`, `fb_abort`, `cmd_pending` and `in_service` are all 0.
- R2: With no commands, the framer sees, for units 0,1,…,NUM_UNITS-1 and then 0 again, an outbound transaction (`fb_op`=0) followed by an inbound transaction (`fb_op`=1) for the same unit, with `fb_unit` giving the unit.
- R3: `cmd_pending` goes to 1 one clock after `cq_nonempty` rises. It stays 1 until the cycle in which `cq_pop` is asserted and is 0 in the cycle after.
- R4: A command arriving during the idle gap is popped with no framer start before it. `in_service` is 1 for exactly the take and reply cycles of each command.
- R5: A command arriving during an outbound transaction does not abort it. It is popped after `fb_done`. The next start afterwards is the inbound transaction (`fb_op`=1) of the same unit.
- R6: A command pending during an inbound transaction makes the block pulse `fb_abort` in the first cycle with `fb_beat`=1 and `fb_done`=0. The command is then popped before any new start.
- R7: After a cut reception, the next start is a retransmit request (`fb_op`=2) to the same unit. The inbound transaction of that unit (`fb_op`=1) follows, and only after it does the next unit's outbound transaction start.
- R8: Every pop is followed in the next cycle by exactly one `rq_push`, whose `rq_data` equals the popped `cq_data`, in pop order.
- R9: Commands already queued are drained one after another with no framer start between them. Polling resumes only after the FIFO is empty.
- R10: `fb_start` is never asserted and `cq_pop` never occurs while a framer transaction is in flight, i.e. between a start and its `fb_done` or `fb_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cq_nonempty | input | 1 | command FIFO holds at least one word |
| cq_data | input | DATA_W | head word of the command FIFO |
| cq_pop | output | 1 | consume the head command |
| rq_push | output | 1 | write `rq_data` into the reply FIFO |
| rq_data | output | DATA_W | reply word |
| fb_start | output | 1 | one-cycle framer start |
| fb_op | output | 2 | 0 outbound, 1 inbound, 2 retransmit request |
| fb_unit | output | $clog2(NUM_UNITS) | addressed unit |
| fb_beat | input | 1 | one word received during an inbound transaction |
| fb_done | input | 1 | framer transaction finished |
| fb_abort | output | 1 | cut the current reception off |
| cmd_pending | output | 1 | a command is waiting to be taken |
| in_service | output | 1 | command take or reply in progress |

## Verification
A corrupted unit index or phase bit shows up at the very next framer start as a wrong `fb_unit` or `fb_op`. That is one transaction after the fault at most. A lost retransmit flag shows up as an inbound start with no request before it, at the first resume after a cut. A wrong state encoding shows up within a cycle as a pop during a transaction in flight, a missing reply or a start between drained commands. Each scenario compares the whole ordered event trace against the expected order.

// File: rtl/cc_pkg.sv
package cc_pkg;
    typedef enum logic [2:0] {
        ST_GAP,
        ST_LAUNCH,
        ST_BUSY,
        ST_TAKE,
        ST_REPLY
    } cc_state_e;

    typedef enum logic [1:0] {
        OP_SEND = 2'd0,
        OP_POLL = 2'd1,
        OP_RETX = 2'd2
    } fb_op_e;
endpackage

// File: rtl/cc_pend.sv
module cc_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_in,
    input  logic taken,
    output logic pend_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= 1'b0;
        else        pend_o <= flag_in & ~taken;
    end
endmodule

// File: rtl/cc_ctx.sv
module cc_ctx #(
    parameter int NUM_UNITS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ev_send_done,
    input  logic                         ev_retx_done,
    input  logic                         ev_poll_done,
    input  logic                         ev_cut,
    output logic [$clog2(NUM_UNITS)-1:0] unit_o,
    output logic                         poll_next_o,
    output logic                         retx_o
);
    localparam int UW = $clog2(NUM_UNITS);
    localparam logic [UW-1:0] LAST = UW'(NUM_UNITS - 1);

    // Unit index, phase and retransmit flag stay frozen while commands are served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_o      <= '0;
            poll_next_o <= 1'b0;
            retx_o      <= 1'b0;
        end else begin
            if (ev_send_done) poll_next_o <= 1'b1;
            if (ev_retx_done) retx_o <= 1'b0;
            if (ev_cut)       retx_o <= 1'b1;
            if (ev_poll_done) begin
                poll_next_o <= 1'b0;
                unit_o      <= (unit_o == LAST) ? '0 : unit_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cc_gap.sv
module cc_gap #(
    parameter int GAP_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    output logic expired
);
    localparam int GW = $clog2(GAP_CYCLES + 1);

    logic [GW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= GW'(GAP_CYCLES);
        else if (reload)         cnt_q <= GW'(GAP_CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cmd_coord.sv
module cmd_coord #(
    parameter int DATA_W     = 8,
    parameter int NUM_UNITS  = 4,
    parameter int GAP_CYCLES = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cq_nonempty,
    input  logic [DATA_W-1:0]            cq_data,
    output logic                         cq_pop,
    output logic                         rq_push,
    output logic [DATA_W-1:0]            rq_data,
    output logic                         fb_start,
    output logic [1:0]                   fb_op,
    output logic [$clog2(NUM_UNITS)-1:0] fb_unit,
    input  logic                         fb_beat,
    input  logic                         fb_done,
    output logic                         fb_abort,
    output logic                         cmd_pending,
    output logic                         in_service
);
    import cc_pkg::*;

    localparam int UW = $clog2(NUM_UNITS);

    cc_state_e         state_q, state_d;
    fb_op_e            cur_op;
    logic              pend, gap_expired, gap_reload;
    logic              ev_send_done, ev_retx_done, ev_poll_done, ev_cut;
    logic [UW-1:0]     unit;
    logic              poll_next, retx;
    logic [DATA_W-1:0] cmd_q;

    cc_pend u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_in(cq_nonempty),
        .taken  (cq_pop),
        .pend_o (pend)
    );

    cc_ctx #(.NUM_UNITS(NUM_UNITS)) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_send_done(ev_send_done),
        .ev_retx_done(ev_retx_done),
        .ev_poll_done(ev_poll_done),
        .ev_cut      (ev_cut),
        .unit_o      (unit),
        .poll_next_o (poll_next),
        .retx_o      (retx)
    );

    cc_gap #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (gap_reload),
        .expired(gap_expired)
    );

    assign cur_op = retx ? OP_RETX : (poll_next ? OP_POLL : OP_SEND);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_GAP;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GAP: begin
                if (pend)             state_d = ST_TAKE;
                else if (gap_expired) state_d = ST_LAUNCH;
            end
            ST_LAUNCH: state_d = ST_BUSY;
            ST_BUSY: begin
                if (fb_done) begin
                    if (cur_op == OP_POLL) state_d = ST_GAP;
                    else if (pend)         state_d = ST_TAKE;
                    else                   state_d = ST_LAUNCH;
                end else if (cur_op == OP_POLL && pend && fb_beat) begin
                    state_d = ST_TAKE;
                end
            end
            ST_TAKE:  state_d = ST_REPLY;
            ST_REPLY: state_d = cq_nonempty ? ST_TAKE : ST_LAUNCH;
            default:  state_d = ST_GAP;
        endcase
    end

    // Outputs and context events
    always_comb begin
        fb_start     = 1'b0;
        fb_abort     = 1'b0;
        cq_pop       = 1'b0;
        rq_push      = 1'b0;
        gap_reload   = 1'b0;
        ev_send_done = 1'b0;
        ev_retx_done = 1'b0;
        ev_poll_done = 1'b0;
        ev_cut       = 1'b0;
        unique case (state_q)
            ST_GAP:    ;
            ST_LAUNCH: fb_start = 1'b1;
            ST_BUSY: begin
                if (fb_done) begin
                    unique case (cur_op)
                        OP_SEND: ev_send_done = 1'b1;
                        OP_RETX: ev_retx_done = 1'b1;
                        default: begin
                            ev_poll_done = 1'b1;
                            gap_reload   = 1'b1;
                        end
                    endcase
                end else if (cur_op == OP_POLL && pend && fb_beat) begin
                    fb_abort = 1'b1;
                    ev_cut   = 1'b1;
                end
            end
            ST_TAKE:  cq_pop  = 1'b1;
            ST_REPLY: rq_push = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (cq_pop) cmd_q <= cq_data;
    end

    assign rq_data     = cmd_q;
    assign fb_op       = cur_op;
    assign fb_unit     = unit;
    assign cmd_pending = pend;
    assign in_service  = (state_q == ST_TAKE) || (state_q == ST_REPLY);
endmodule

// File: rtl/cmd_coord_chk.sv
module cmd_coord_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cq_pop,
    input logic [DATA_W-1:0] cq_data,
    input logic              rq_push,
    input logic [DATA_W-1:0] rq_data,
    input logic              fb_start,
    input logic              fb_beat,
    input logic              fb_done,
    input logic              fb_abort,
    input logic              cmd_pending,
    input logic              in_service
);
    logic inflight_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                   inflight_q <= 1'b0;
        else if (fb_start)            inflight_q <= 1'b1;
        else if (fb_done || fb_abort) inflight_q <= 1'b0;
    end

    a_r10_no_start_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q |-> !fb_start);

    a_r10_no_pop_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q |-> !cq_pop);

    a_r8_reply_follows_pop: assert property (@(posedge clk) disable iff (!rst_n)
        cq_pop |=> rq_push && rq_data == $past(cq_data));

    a_r8_no_orphan_reply: assert property (@(posedge clk) disable iff (!rst_n)
        rq_push |-> $past(cq_pop));

    a_r6_cut_only_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
        fb_abort |-> cmd_pending && fb_beat && !fb_done);

    a_r3_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pending && !cq_pop |=> cmd_pending);

    a_r4_service_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cq_pop || rq_push) |-> in_service);

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cq_pop, rq_push, fb_start}));
endmodule

bind cmd_coord cmd_coord_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cq_pop     (cq_pop),
    .cq_data    (cq_data),
    .rq_push    (rq_push),
    .rq_data    (rq_data),
    .fb_start   (fb_start),
    .fb_beat    (fb_beat),
    .fb_done    (fb_done),
    .fb_abort   (fb_abort),
    .cmd_pending(cmd_pending),
    .in_service (in_service)
);

// File: tb/cmd_coord_tb_top.sv
module cmd_coord_tb_top;
    localparam int DW = 8;
    localparam int NU = 4;
    localparam int GAP = 8;
    localparam int SEND_LEN = 6;
    localparam int POLL_LEN = 10;

    localparam int K_START = 1, K_POP = 2, K_PUSH = 3, K_ABORT = 4, K_DONE = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cq_nonempty;
    logic [DW-1:0] cq_data;
    logic          cq_pop, rq_push, fb_start, fb_abort, cmd_pending, in_service;
    logic [DW-1:0] rq_data;
    logic [1:0]    fb_op;
    logic [1:0]    fb_unit;
    logic          fb_beat = 1'b0;
    logic          fb_done = 1'b0;

    logic [DW-1:0] fifo_mem [16];
    int            wr_ptr = 0;
    int            rd_ptr = 0;

    int ev_kind [1024];
    int ev_val  [1024];
    int ev_cyc  [1024];
    int n_ev = 0;
    int cyc = 0;
    int svc_cycles = 0;
    int n_chk = 0;
    int n_fail = 0;

    assign cq_nonempty = (wr_ptr != rd_ptr);
    assign cq_data     = fifo_mem[rd_ptr % 16];

    always #10 clk = ~clk;

    cmd_coord #(.DATA_W(DW), .NUM_UNITS(NU), .GAP_CYCLES(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cq_nonempty(cq_nonempty), .cq_data(cq_data), .cq_pop(cq_pop),
        .rq_push(rq_push), .rq_data(rq_data),
        .fb_start(fb_start), .fb_op(fb_op), .fb_unit(fb_unit),
        .fb_beat(fb_beat), .fb_done(fb_done), .fb_abort(fb_abort),
        .cmd_pending(cmd_pending), .in_service(in_service)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int next_ev(input int kind, input int from);
        for (int i = from; i < n_ev; i++)
            if (ev_kind[i] == kind) return i;
        return -1;
    endfunction

    function automatic int count_ev(input int kind, input int from, input int upto);
        int c = 0;
        for (int i = from; i < upto && i < n_ev; i++)
            if (ev_kind[i] == kind) c++;
        return c;
    endfunction

    task automatic wait_ev(input int kind, input int from, output int idx);
        idx = next_ev(kind, from);
        while (idx < 0) begin
            @(negedge clk); #4;
            idx = next_ev(kind, from);
        end
    endtask

    task automatic push_cmd(input logic [DW-1:0] d);
        fifo_mem[wr_ptr % 16] = d;
        wr_ptr++;
    endtask

    // Event monitor
    initial begin
        forever begin
            @(negedge clk); #2;
            cyc++;
            if (in_service) svc_cycles++;
            if (fb_start) begin ev_kind[n_ev] = K_START; ev_val[n_ev] = fb_op * 16 + fb_unit; ev_cyc[n_ev] = cyc; n_ev++; end
            if (cq_pop)   begin ev_kind[n_ev] = K_POP;   ev_val[n_ev] = 0; ev_cyc[n_ev] = cyc; n_ev++; end
            if (rq_push)  begin ev_kind[n_ev] = K_PUSH;  ev_val[n_ev] = rq_data; ev_cyc[n_ev] = cyc; n_ev++; end
            if (fb_abort) begin ev_kind[n_ev] = K_ABORT; ev_val[n_ev] = 0; ev_cyc[n_ev] = cyc; n_ev++; end
            if (fb_done)  begin ev_kind[n_ev] = K_DONE;  ev_val[n_ev] = fb_op; ev_cyc[n_ev] = cyc; n_ev++; end
        end
    end

    // FIFO read side: a pop moves the head one cycle later
    initial begin
        logic pop_seen;
        pop_seen = 1'b0;
        forever begin
            @(negedge clk);
            if (pop_seen) rd_ptr++;
            #1 pop_seen = cq_pop;
        end
    end

    // Framer model
    initial begin
        forever begin
            @(negedge clk);
            fb_beat = 1'b0;
            fb_done = 1'b0;
            #1;
            if (fb_start) begin
                int len;
                logic inbound;
                inbound = (fb_op == 2'd1);
                len = inbound ? POLL_LEN : SEND_LEN;
                for (int i = 0; i < len; i++) begin
                    @(negedge clk);
                    fb_beat = inbound && (i % 2 == 1);
                    fb_done = (i == len - 1);
                    #1;
                    if (fb_abort || fb_done) break;
                    if (i < len - 1) begin
                        // keep strobe single-cycle
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    task automatic t_reset_and_rotation();
        int idx, from;
        repeat (3) @(negedge clk);
        #4;
        check("R1", {fb_start, cq_pop, rq_push, fb_abort, cmd_pending, in_service}, 0, "outputs in reset");
        rst_n = 1'b1;
        @(negedge clk); #4;
        check("R1", {fb_start, cq_pop, rq_push, fb_abort, cmd_pending, in_service}, 0, "outputs after reset");
        from = 0;
        for (int k = 0; k <= 2 * NU; k++) begin
            wait_ev(K_START, from, idx);
            check("R2", ev_val[idx], (k % 2) * 16 + ((k / 2) % NU), "op*16+unit in rotation");
            from = idx + 1;
        end
    endtask

    task automatic t_idle_cmd();
        int d, s, mark, p, q, svc0, u;
        wait_ev(K_START, n_ev, s);
        while (ev_val[s] / 16 != 1) wait_ev(K_START, s + 1, s);
        u = ev_val[s] % 16;
        wait_ev(K_DONE, s, d);
        @(negedge clk); @(negedge clk); #4;
        check("R3", cmd_pending, 0, "pending before command");
        svc0 = svc_cycles;
        mark = n_ev;
        @(negedge clk);
        push_cmd(8'hA1);
        @(negedge clk); #4;
        check("R3", cmd_pending, 1, "pending one cycle after nonempty");
        wait_ev(K_POP, mark, p);
        check("R4", count_ev(K_START, mark, p), 0, "starts before idle pop");
        wait_ev(K_PUSH, p, q);
        check("R8", ev_val[q], 8'hA1, "reply data idle");
        check("R8", ev_cyc[q] - ev_cyc[p], 1, "reply delay");
        #20;
        check("R3", cmd_pending, 0, "pending cleared after pop");
        check("R4", svc_cycles - svc0, 2, "in_service cycles");
        wait_ev(K_START, q, s);
        check("R2", ev_val[s], (u + 1) % NU, "resume with next outbound");
    endtask

    task automatic t_send_cmd();
        int s, mark, p, q, u;
        wait_ev(K_START, n_ev, s);
        while (ev_val[s] / 16 != 0) wait_ev(K_START, s + 1, s);
        u = ev_val[s] % 16;
        @(negedge clk);
        mark = n_ev;
        push_cmd(8'hB2);
        wait_ev(K_POP, mark, p);
        check("R5", count_ev(K_ABORT, mark, p), 0, "no abort of outbound");
        check("R5", count_ev(K_DONE, mark, p), 1, "outbound finished before pop");
        check("R5", count_ev(K_START, mark, p), 0, "no start before pop");
        wait_ev(K_PUSH, p, q);
        check("R8", ev_val[q], 8'hB2, "reply data outbound case");
        wait_ev(K_START, q, s);
        check("R5", ev_val[s], 16 + u, "resume inbound same unit");
    endtask

    task automatic t_recv_cmd();
        int s, mark, a, p, q, u;
        wait_ev(K_START, n_ev, s);
        while (ev_val[s] / 16 != 1) wait_ev(K_START, s + 1, s);
        u = ev_val[s] % 16;
        @(negedge clk);
        mark = n_ev;
        push_cmd(8'hC3);
        wait_ev(K_ABORT, mark, a);
        check("R6", count_ev(K_DONE, mark, a), 0, "cut before inbound done");
        wait_ev(K_POP, a, p);
        check("R6", count_ev(K_START, a, p), 0, "no start between cut and pop");
        wait_ev(K_PUSH, p, q);
        check("R8", ev_val[q], 8'hC3, "reply data inbound case");
        wait_ev(K_START, q, s);
        check("R7", ev_val[s], 32 + u, "retransmit request same unit");
        wait_ev(K_START, s + 1, s);
        check("R7", ev_val[s], 16 + u, "inbound again after request");
        wait_ev(K_START, s + 1, s);
        check("R7", ev_val[s], (u + 1) % NU, "next unit outbound after retry");
    endtask

    task automatic t_back_to_back();
        int s, mark, p1, p2, q1, q2, u;
        wait_ev(K_START, n_ev, s);
        while (ev_val[s] / 16 != 0) wait_ev(K_START, s + 1, s);
        u = ev_val[s] % 16;
        @(negedge clk);
        mark = n_ev;
        push_cmd(8'hD1);
        @(negedge clk);
        push_cmd(8'hD2);
        wait_ev(K_POP, mark, p1);
        wait_ev(K_POP, p1 + 1, p2);
        wait_ev(K_PUSH, p1, q1);
        wait_ev(K_PUSH, q1 + 1, q2);
        check("R9", ev_val[q1], 8'hD1, "first drained reply");
        check("R9", ev_val[q2], 8'hD2, "second drained reply");
        check("R9", count_ev(K_START, p1, q2), 0, "no start while draining");
        wait_ev(K_START, q2, s);
        check("R9", ev_val[s], 16 + u, "resume after drain");
        check("R9", wr_ptr - rd_ptr, 0, "command FIFO empty at resume");
    endtask

    initial begin
        t_reset_and_rotation();
        t_idle_cmd();
        t_send_cmd();
        t_recv_cmd();
        t_back_to_back();
        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule